// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch Controller

This block picks which of three clocks drives the main output clock: a loop (frequency-locked) output, an internal reference, or an external reference. Software writes the requested source and reference through a small synchronous register bus. It may do so at any moment. The hardware keeps the request apart from the actual state. A switch goes ahead only when the requested source is ready, and a read-only status register reports the source and reference that are really in use. A request for a source that is not ready is held off silently. The output stays on the old source until the new one becomes available.

Each source clock passes through a gate cell that synchronises its enable into that clock's own domain and changes state only on that clock's falling edge. The sequencer turns the old gate off and waits until it sees the gate off. Only then does it turn the new gate on, so the merged output never carries a runt pulse. The block also models the loop's lock flag. The flag drops whenever the oscillator range read-back changes or the loop reference changes, and it returns after a fixed startup count of `clk_i` cycles. `clk_i` is the reference-rate control clock. A low-power bit turns the loop off when the loop is neither driving the output nor the target of a switch. While that bit is set, the range field refuses writes.

Register map (8-bit data, 2-bit address): address 0 is CTRL, address 1 is RANGE, and address 2 is STAT (read-only). Address 3 reads as zero. Source codes are 0 = loop, 1 = internal reference, 2 = external reference, and 3 = reserved (never available).

Top module: `clk_sw_ctrl`

## Requirements
- R1: After reset, CTRL reads 0x00 (reference select 0 = internal, source request 0 = loop, low-power 0), RANGE reads 0x00, STAT shows source 0 with lock 0, `loop_en_o` is 1, and `clk_o` follows `clk_loop_i`.
- R2: CTRL bit 0 is the reference request, bits [2:1] are the source request and bit 3 is low-power. It accepts any write at any time and reads back the written value on the next cycle, whether or not the switch has happened.
- R3: A request for an available source different from the current one completes through the gate handshake. STAT bits [2:1] then show the new code, and `clk_o` runs at that source's period. Availability is: loop when locked, internal when `irc_rdy_i`, external when `ext_rdy_i`.
- R4: A request for an unavailable source, or for reserved code 3, leaves STAT bits [2:1] and the `clk_o` period unchanged. The switch goes ahead later if the source becomes available.
- R5: Break-before-make: `clk_o` never shows a high or low pulse shorter than the shortest source half-period, and no two gates are ever on together.
- R6: STAT bit 0 (reference in use) takes the requested reference one cycle after the write. A request for the external reference is held off while `ext_rdy_i` is 0. `loop_ref_o` equals STAT bit 0.
- R7: While low-power is 1, writes to RANGE are ignored: RANGE bits [1:0] and `osc_range_o` keep their value.
- R8: A write to RANGE drives `osc_range_o` at once. The read-back bits RANGE [5:4] take the new value exactly RANGE_LAT (default 3) cycles after the write edge and keep the old value before that.
- R9: A change in the range read-back or in the reference in use clears the lock flag (STAT bit 3, `loop_lock_o`) at that edge. The flag returns exactly STARTUP_CYC (default 8) cycles later.
- R10: With low-power set and the loop neither driving nor targeted, `loop_en_o` is 0 and lock is 0, so a request for the loop is held off. Clearing low-power re-enables the loop, which locks and then completes the switch.
- R11: Writes to STAT have no effect on STAT or CTRL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control and reference-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| clk_loop_i | input | 1 | Loop output clock (source 0) |
| clk_irc_i | input | 1 | Internal reference clock (source 1) |
| clk_ext_i | input | 1 | External reference clock (source 2) |
| irc_rdy_i | input | 1 | Internal reference ready |
| ext_rdy_i | input | 1 | External reference ready |
| clk_o | output | 1 | Glitch-free selected output clock |
| loop_en_o | output | 1 | Loop enable |
| loop_lock_o | output | 1 | Modelled loop lock flag (registered) |
| loop_ref_o | output | 1 | Reference in use by the loop (1 = external) |
| osc_range_o | output | 2 | Requested oscillator range |

## Verification
The source switch is driven through every useful ordering: loop to internal, internal to external while external is not ready and then after it becomes ready, a reserved code, and back to the loop with the loop disabled and then enabled. The bench measures the `clk_o` period after each step, because the three source periods differ (6, 16, 10). This separates a switch that truly took effect from a status field that merely changed. The range and reference writes are counted cycle by cycle against the read-back lag and the lock restart. This exposes a delay that is off by one or a relock that is missing. A pulse-width monitor on `clk_o` over the whole run catches any make-before-break overlap.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_W   = 2;
  localparam int NCODE   = 1 << SRC_W;
  localparam int RANGE_W = 2;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  localparam logic [SRC_W-1:0] SRC_LOOP = 2'd0;
  localparam logic [SRC_W-1:0] SRC_IRC  = 2'd1;
  localparam logic [SRC_W-1:0] SRC_EXT  = 2'd2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RANGE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;

  typedef enum logic [1:0] {SW_IDLE, SW_DROP, SW_RAISE} sw_state_e;
endpackage

// File: rtl/clk_sw_gate.sv
module clk_sw_gate #(
  parameter bit RST_ON = 1'b0
) (
  input  logic clk_i,
  input  logic clk_src_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o,
  output logic ack_o
);
  logic [1:0] sync_q;
  logic       gate_q;
  logic [1:0] ack_q;

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {RST_ON, RST_ON};
    else         sync_q <= {sync_q[0], en_i};
  end

  // gate changes only while the source is low
  always_ff @(negedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= RST_ON;
    else         gate_q <= sync_q[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= {RST_ON, RST_ON};
    else         ack_q <= {ack_q[0], gate_q};
  end

  assign gclk_o = clk_src_i & gate_q;
  assign ack_o  = ack_q[1];
endmodule

// File: rtl/clk_sw_regs.sv
module clk_sw_regs
  import clk_sw_pkg::*;
#(
  parameter int RANGE_LAT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               ext_rdy_i,
  input  logic [SRC_W-1:0]   src_st_i,
  input  logic               lock_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [SRC_W-1:0]   src_req_o,
  output logic               low_pwr_o,
  output logic               ref_st_o,
  output logic [RANGE_W-1:0] range_o,
  output logic               relock_o
);
  localparam int DLY_W = (RANGE_LAT > 2) ? $clog2(RANGE_LAT) : 1;

  logic               ref_sel_q, ref_st_q, low_pwr_q;
  logic [SRC_W-1:0]   src_req_q;
  logic [RANGE_W-1:0] range_q, rng_act_q;
  logic               rng_busy_q;
  logic [DLY_W-1:0]   dly_q;
  logic               wr_ctrl, wr_rng, ref_nxt, ref_chg, rng_done;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:4];

  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_rng   = wr_en_i && (addr_i == ADDR_RANGE) && !low_pwr_q;
  assign ref_nxt  = (ref_sel_q && !ext_rdy_i) ? ref_st_q : ref_sel_q;
  assign ref_chg  = ref_nxt != ref_st_q;
  assign rng_done = rng_busy_q && (dly_q == '0);
  assign relock_o = (rng_done && (range_q != rng_act_q)) || ref_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_sel_q <= 1'b0;
      src_req_q <= SRC_LOOP;
      low_pwr_q <= 1'b0;
      ref_st_q  <= 1'b0;
    end else begin
      ref_st_q <= ref_nxt;
      if (wr_ctrl) begin
        ref_sel_q <= wdata_i[0];
        src_req_q <= wdata_i[2:1];
        low_pwr_q <= wdata_i[3];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q    <= '0;
      rng_act_q  <= '0;
      rng_busy_q <= 1'b0;
      dly_q      <= '0;
    end else if (wr_rng) begin
      range_q    <= wdata_i[RANGE_W-1:0];
      rng_busy_q <= 1'b1;
      dly_q      <= DLY_W'(RANGE_LAT - 1);
    end else if (rng_done) begin
      rng_act_q  <= range_q;
      rng_busy_q <= 1'b0;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL:  rdata_o = DATA_W'({low_pwr_q, src_req_q, ref_sel_q});
      ADDR_RANGE: rdata_o = DATA_W'({rng_act_q, 2'b00, range_q});
      ADDR_STAT:  rdata_o = DATA_W'({lock_i, src_st_i, ref_st_q});
      default:    rdata_o = '0;
    endcase
  end

  assign src_req_o = src_req_q;
  assign low_pwr_o = low_pwr_q;
  assign ref_st_o  = ref_st_q;
  assign range_o   = range_q;

  a_r7_lp_range_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_RANGE && low_pwr_q) |=> $stable(range_q));
  a_r8_no_early_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rng_busy_q && dly_q != '0 && !wr_rng) |=> $stable(rng_act_q));
  a_r6_ext_ref_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_st_q) |-> $past(ext_rdy_i));
endmodule

// File: rtl/clk_sw_lock.sv
module clk_sw_lock #(
  parameter int STARTUP_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loop_en_i,
  input  logic relock_i,
  output logic lock_o
);
  localparam int CNT_W = $clog2(STARTUP_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (relock_i || !loop_en_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      if (cnt_q == CNT_W'(STARTUP_CYC - 1)) lock_q <= 1'b1;
      else                                 cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign lock_o = lock_q;

  a_r9_relock_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_i |=> !lock_o);
  a_r10_disabled_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |=> !lock_o);
  a_r9_rise_needs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(loop_en_i) && !$past(relock_i)));
endmodule

// File: rtl/clk_sw_seq.sv
module clk_sw_seq
  import clk_sw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_req_i,
  input  logic [NSRC-1:0]  avail_i,
  input  logic [NSRC-1:0]  ack_i,
  output logic [NSRC-1:0]  sel_o,
  output logic [SRC_W-1:0] src_st_o,
  output logic [SRC_W-1:0] tgt_o,
  output logic             busy_o
);
  sw_state_e        state_q;
  logic [NSRC-1:0]  sel_q;
  logic [SRC_W-1:0] src_st_q, tgt_q;
  logic [NCODE-1:0] avail_pad, ack_pad;
  logic             req_ok;

  assign avail_pad = NCODE'(avail_i);
  assign ack_pad   = NCODE'(ack_i);
  assign req_ok    = (src_req_i != src_st_q) && avail_pad[src_req_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SW_IDLE;
      sel_q    <= NSRC'(1) << SRC_LOOP;
      src_st_q <= SRC_LOOP;
      tgt_q    <= SRC_LOOP;
    end else begin
      case (state_q)
        SW_IDLE: if (req_ok) begin
          tgt_q   <= src_req_i;
          sel_q   <= sel_q & ~(NSRC'(1) << src_st_q);
          state_q <= SW_DROP;
        end
        SW_DROP: if (!ack_pad[src_st_q]) begin
          sel_q   <= sel_q | (NSRC'(1) << tgt_q);
          state_q <= SW_RAISE;
        end
        SW_RAISE: if (ack_pad[tgt_q]) begin
          src_st_q <= tgt_q;
          state_q  <= SW_IDLE;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign sel_o    = sel_q;
  assign src_st_o = src_st_q;
  assign tgt_o    = tgt_q;
  assign busy_o   = state_q != SW_IDLE;

  a_r5_one_gate_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_i));
  a_r5_one_gate_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));
  a_r3_switch_gate_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_st_q) |-> (ack_i == sel_q));
endmodule

// File: rtl/clk_sw_ctrl.sv
module clk_sw_ctrl
  import clk_sw_pkg::*;
#(
  parameter int STARTUP_CYC = 8,
  parameter int RANGE_LAT   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               clk_loop_i,
  input  logic               clk_irc_i,
  input  logic               clk_ext_i,
  input  logic               irc_rdy_i,
  input  logic               ext_rdy_i,
  output logic               clk_o,
  output logic               loop_en_o,
  output logic               loop_lock_o,
  output logic               loop_ref_o,
  output logic [RANGE_W-1:0] osc_range_o
);
  logic [SRC_W-1:0] src_req, src_st, tgt;
  logic             low_pwr, ref_st, relock, lock, busy, loop_en;
  logic [NSRC-1:0]  src_clk, sel, ack, gclk, avail;

  assign src_clk = {clk_ext_i, clk_irc_i, clk_loop_i};
  assign avail   = {ext_rdy_i, irc_rdy_i, lock};
  assign loop_en = !low_pwr || (src_st == SRC_LOOP) || (busy && tgt == SRC_LOOP);

  clk_sw_regs #(.RANGE_LAT(RANGE_LAT)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .ext_rdy_i,
    .src_st_i(src_st), .lock_i(lock), .rdata_o,
    .src_req_o(src_req), .low_pwr_o(low_pwr), .ref_st_o(ref_st),
    .range_o(osc_range_o), .relock_o(relock)
  );

  clk_sw_lock #(.STARTUP_CYC(STARTUP_CYC)) u_lock (
    .clk_i, .rst_ni, .loop_en_i(loop_en), .relock_i(relock), .lock_o(lock)
  );

  clk_sw_seq u_seq (
    .clk_i, .rst_ni, .src_req_i(src_req), .avail_i(avail), .ack_i(ack),
    .sel_o(sel), .src_st_o(src_st), .tgt_o(tgt), .busy_o(busy)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    clk_sw_gate #(.RST_ON(g == int'(SRC_LOOP))) u_gate (
      .clk_i, .clk_src_i(src_clk[g]), .rst_ni, .en_i(sel[g]),
      .gclk_o(gclk[g]), .ack_o(ack[g])
    );
  end

  assign clk_o       = |gclk;
  assign loop_en_o   = loop_en;
  assign loop_lock_o = lock;
  assign loop_ref_o  = ref_st;
endmodule

// File: tb/clk_sw_ctrl_tb.sv
module clk_sw_ctrl_tb;
  localparam int CLK_PER = 10;
  localparam int MIN_PULSE = 3;

  logic       clk_i = 0, rst_ni = 0, wr_en_i = 0;
  logic [1:0] addr_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  logic       clk_loop_i = 0, clk_irc_i = 0, clk_ext_i = 0;
  logic       irc_rdy_i = 1, ext_rdy_i = 0;
  logic       clk_o, loop_en_o, loop_lock_o, loop_ref_o;
  logic [1:0] osc_range_o;

  int checks = 0, fails = 0, short_pulses = 0, cyc = 0;
  longint t_rise = 0, t_fall = 0;

  always #(CLK_PER/2) clk_i = ~clk_i;
  always #3 clk_loop_i = ~clk_loop_i;
  always #8 clk_irc_i = ~clk_irc_i;
  always #5 clk_ext_i = ~clk_ext_i;

  clk_sw_ctrl u_dut (.*);

  always @(posedge clk_o) begin
    if ($time - t_fall < MIN_PULSE) short_pulses++;
    t_rise = $time;
  end
  always @(negedge clk_o) begin
    if ($time - t_rise < MIN_PULSE) short_pulses++;
    t_fall = $time;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic stat_src(output int s);
    logic [7:0] d; rd(2'd2, d); s = int'(d[2:1]);
  endtask

  task automatic stat_lock(output int l);
    logic [7:0] d; rd(2'd2, d); l = int'(d[3]);
  endtask

  task automatic meas(output int p);
    longint t0;
    @(posedge clk_o); t0 = $time;
    @(posedge clk_o); p = int'($time - t0);
    @(negedge clk_i);
  endtask

  task automatic poll_src(int exp, int max);
    int s;
    for (int i = 0; i < max; i++) begin
      stat_src(s);
      if (s == exp) break;
      tick(1);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d; int p;
    rd(2'd0, d); chk("R1 ctrl reset", d, 8'h00);
    rd(2'd1, d); chk("R1 range reset", d, 8'h00);
    rd(2'd2, d); chk("R1 stat reset", d, 8'h00);
    chk("R1 loop_en reset", loop_en_o, 1);
    rst_ni = 1;
    tick(7);  chk("R1 lock low before startup", loop_lock_o, 0);
    tick(1);  chk("R9 lock after startup count", loop_lock_o, 1);
    meas(p);  chk("R1 clk_o follows loop", p, 6);
  endtask

  task automatic t_to_irc;
    int s, p;
    wr(2'd0, 8'h02);
    poll_src(1, 100);
    stat_src(s); chk("R3 status internal", s, 1);
    meas(p);     chk("R3 period internal", p, 16);
  endtask

  task automatic t_ref_held;
    logic [7:0] d;
    wr(2'd0, 8'h03);
    tick(20);
    rd(2'd2, d); chk("R6 ref held while ext not ready", d[0], 0);
    chk("R6 loop_ref_o held", loop_ref_o, 0);
    wr(2'd0, 8'h02);
  endtask

  task automatic t_ext_held;
    logic [7:0] d; int s, p;
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R2 ctrl readback of request", d, 8'h04);
    tick(60);
    stat_src(s); chk("R4 status held on unready source", s, 1);
    meas(p);     chk("R4 output held on unready source", p, 16);
    ext_rdy_i = 1;
    poll_src(2, 100);
    stat_src(s); chk("R4 switch resumes when ready", s, 2);
    meas(p);     chk("R3 period external", p, 10);
  endtask

  task automatic t_ref_switch;
    logic [7:0] d; int l;
    wr(2'd0, 8'h05);
    tick(1);
    rd(2'd2, d); chk("R6 ref status external", d[0], 1);
    chk("R6 loop_ref_o external", loop_ref_o, 1);
    chk("R9 lock cleared on ref change", loop_lock_o, 0);
    tick(7);  chk("R9 lock still low", loop_lock_o, 0);
    tick(1);  stat_lock(l); chk("R9 lock back after ref change", l, 1);
  endtask

  task automatic t_range;
    logic [7:0] d;
    wr(2'd1, 8'h02);
    chk("R8 osc_range_o immediate", osc_range_o, 2);
    rd(2'd1, d); chk("R8 range request read", d[1:0], 2);
    chk("R8 readback old at write", d[5:4], 0);
    tick(2);
    rd(2'd1, d); chk("R8 readback old after 2 cycles", d[5:4], 0);
    chk("R9 lock kept before range done", loop_lock_o, 1);
    tick(1);
    rd(2'd1, d); chk("R8 readback new after 3 cycles", d[5:4], 2);
    chk("R9 lock cleared on range done", loop_lock_o, 0);
    tick(7);  chk("R9 lock low during startup", loop_lock_o, 0);
    tick(1);  chk("R9 lock back after range change", loop_lock_o, 1);
  endtask

  task automatic t_reserved;
    int s;
    wr(2'd0, 8'h07);
    tick(40);
    stat_src(s); chk("R4 reserved code ignored", s, 2);
    wr(2'd0, 8'h05);
  endtask

  task automatic t_stat_ro;
    logic [7:0] s0, d;
    rd(2'd2, s0);
    wr(2'd2, 8'hFF);
    tick(2);
    rd(2'd2, d); chk("R11 stat unchanged by write", d, s0);
    rd(2'd0, d); chk("R11 ctrl unchanged by stat write", d, 8'h05);
  endtask

  task automatic t_low_power;
    logic [7:0] d; int s, p;
    wr(2'd0, 8'h0D);
    chk("R10 loop disabled in low power", loop_en_o, 0);
    tick(1); chk("R10 lock low in low power", loop_lock_o, 0);
    wr(2'd1, 8'h01);
    chk("R7 osc_range_o kept", osc_range_o, 2);
    rd(2'd1, d); chk("R7 range request kept", d[1:0], 2);
    tick(5);
    rd(2'd1, d); chk("R7 readback kept", d[5:4], 2);
    wr(2'd0, 8'h09);
    tick(60);
    stat_src(s); chk("R10 loop request held off", s, 2);
    chk("R10 loop stays disabled", loop_en_o, 0);
    wr(2'd0, 8'h01);
    chk("R10 loop enabled after clearing", loop_en_o, 1);
    poll_src(0, 200);
    stat_src(s); chk("R10 switch to loop completes", s, 0);
    meas(p);     chk("R3 period loop", p, 6);
    wr(2'd1, 8'h01);
    chk("R7 range writable again", osc_range_o, 1);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_to_irc();
    t_ref_held();
    t_ext_held();
    t_ref_switch();
    t_range();
    t_reserved();
    t_stat_ro();
    t_low_power();
    chk("R5 no short pulse on clk_o", short_pulses, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule